// File: doc/BRIEF.md
# NOR Flash Erase Command Sequencer with Suspend

This block is the command front end and erase controller for one bank of a word-wide NOR flash model. It watches host write cycles, each a word address and a 16-bit data word, and recognises two unlock-protected erase commands. Each command is six writes long. One erases the whole bank. The other erases a single sector. The array operation itself is stood in for by a cycle counter. A sector erase first opens a short time-out window. During that window, or during the erase itself, it can be suspended and later resumed. A chip erase cannot be interrupted by any write.

While an operation is in progress, a read whose address falls in an erase-selected sector returns a status byte in place of array data. Reads of other sectors, and every read once the bank is back in read mode, are flagged as array reads. The active-low reset is asynchronous and aborts any operation at once. Write and read strobes are single-cycle and always accepted, so there is no back-pressure. Each read is answered by one result on `rd_valid` exactly one cycle later.

Top module: `nor_erase_seq`

## Requirements
- R1: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h, issued in this order, start a chip erase. The unlock addresses are compared on wr_addr[10:0] and the data on all 16 bits. `busy` rises in the cycle after the sixth write and stays high for exactly ERASE_CYC cycles.
- R2: The same five prefix writes followed by 30h to any address start a sector erase. The sector is wr_addr[ADDR_W-1:SECT_SHIFT]. `busy` is high for TMO_CYC time-out cycles plus ERASE_CYC erase cycles.
- R3: Any write that does not match the next expected step returns the decoder to its first step, and no erase starts. A complete, correct sequence afterwards is accepted.
- R4: During a chip erase every write is ignored, including B0h and complete new command sequences. `suspended` never rises.
- R5: B0h written during the sector-erase time-out suspends at once: `suspended` is high and `busy` low in the next cycle. Resume then runs the full ERASE_CYC cycles.
- R6: B0h written while a sector erase is running takes effect after exactly SUSP_LAT cycles, during which erasing continues. Counting time-out and erase cycles outside the suspend, the operation still totals TMO_CYC+ERASE_CYC busy cycles.
- R7: Resume (30h) is honoured only while suspended. Other writes while suspended, and 30h while running, change nothing.
- R8: A read of a sector selected for erase, while erasing or suspended, gives `rd_is_status`=1 one cycle later. Reads of unselected sectors, and all reads in read mode, give `rd_is_status`=0 and `rd_status`=0. A chip erase selects every sector.
- R9: Status byte: bit 7 is 0 while erasing and 1 while suspended. Bit 6 toggles on each status read while erasing and holds while suspended. Bit 2 toggles on each status read in both states. The remaining bits are 0. Both toggle bits reset to 0.
- R10: Asserting `rst_n` low aborts any operation immediately: `busy`, `suspended` and `rd_valid` are 0, and no sector stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_valid | output | 1 | Read result valid, one cycle after rd_en |
| rd_is_status | output | 1 | Result is a status byte rather than array data |
| rd_status | output | 8 | Status byte (bits 7, 6, 2) |
| busy | output | 1 | Time-out or erase in progress |
| suspended | output | 1 | Sector erase suspended |

## Verification
`busy` and `suspended` are registered, so each command's effect is due in the cycle after the write edge. The bench drives on the falling edge and samples on the next falling edge, which is the first point where the new state is visible. The suspend latency is measured by counting falling-edge samples until `suspended` rises, and the expected count is SUSP_LAT. Erase lengths are checked by a monitor that counts falling-edge samples with `busy` high and compares the total with sums of TMO_CYC and ERASE_CYC. Read results are sampled one cycle after `rd_en`, and the bench keeps its own model of the two toggle bits.

// File: rtl/nes_pkg.sv
package nes_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TMO,
    ST_RUN,
    ST_SPEND,
    ST_SUSP,
    ST_CHIP
  } est_t;

  localparam logic [10:0] UNLK_A = 11'h555;
  localparam logic [10:0] UNLK_B = 11'h2AA;
  localparam logic [15:0] D_AA   = 16'h00AA;
  localparam logic [15:0] D_55   = 16'h0055;
  localparam logic [15:0] D_80   = 16'h0080;
  localparam logic [15:0] D_CHIP = 16'h0010;
  localparam logic [15:0] D_SECT = 16'h0030;
  localparam logic [15:0] D_SUSP = 16'h00B0;
  localparam logic [15:0] D_RES  = 16'h0030;
endpackage

// File: rtl/nes_unlock_dec.sv
module nes_unlock_dec
  import nes_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        wr_en,
  input  logic [10:0] wr_low,
  input  logic [15:0] wr_data,
  output logic        chip_go,
  output logic        sec_go
);
  logic [2:0] step;
  logic       hit;

  always_comb begin
    case (step)
      3'd0:    hit = (wr_low == UNLK_A) && (wr_data == D_AA);
      3'd1:    hit = (wr_low == UNLK_B) && (wr_data == D_55);
      3'd2:    hit = (wr_low == UNLK_A) && (wr_data == D_80);
      3'd3:    hit = (wr_low == UNLK_A) && (wr_data == D_AA);
      3'd4:    hit = (wr_low == UNLK_B) && (wr_data == D_55);
      default: hit = 1'b0;
    endcase
  end

  assign chip_go = en && wr_en && (step == 3'd5) && (wr_low == UNLK_A) && (wr_data == D_CHIP);
  assign sec_go  = en && wr_en && (step == 3'd5) && (wr_data == D_SECT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step <= 3'd0;
    else if (!en)    step <= 3'd0;
    else if (wr_en)  step <= hit ? step + 3'd1 : 3'd0;
  end

  AST_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd5) else $error("decoder step out of range"); // R3
  AST_GO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chip_go, sec_go})) else $error("two erase starts at once"); // R2
endmodule

// File: rtl/nes_erase_ctrl.sv
module nes_erase_ctrl
  import nes_pkg::*;
#(
  parameter int SECT_W    = 4,
  parameter int TMO_CYC   = 8,
  parameter int ERASE_CYC = 40,
  parameter int SUSP_LAT  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [15:0]            wr_data,
  input  logic                   chip_go,
  input  logic                   sec_go,
  input  logic [SECT_W-1:0]      sec_idx,
  output est_t                   state,
  output logic [(1<<SECT_W)-1:0] sel_map
);
  localparam int NSECT = 1 << SECT_W;
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int RW = $clog2(ERASE_CYC + 1);
  localparam int LW = $clog2(SUSP_LAT + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(TMO_CYC);
  localparam logic [RW-1:0] R_LOAD = RW'(ERASE_CYC);
  localparam logic [LW-1:0] L_LOAD = LW'(SUSP_LAT);

  logic [TW-1:0] tmo;
  logic [RW-1:0] rem;
  logic [LW-1:0] lat;
  logic          cmd_susp, cmd_res, last;

  assign cmd_susp = wr_en && (wr_data == D_SUSP);
  assign cmd_res  = wr_en && (wr_data == D_RES);
  assign last     = (rem == RW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tmo     <= '0;
      rem     <= '0;
      lat     <= '0;
      sel_map <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (chip_go) begin
            state   <= ST_CHIP;
            rem     <= R_LOAD;
            sel_map <= '1;
          end else if (sec_go) begin
            state   <= ST_TMO;
            tmo     <= T_LOAD;
            rem     <= R_LOAD;
            sel_map <= NSECT'(1) << sec_idx;
          end
        end
        ST_TMO: begin
          if (cmd_susp)             state <= ST_SUSP;
          else if (tmo == TW'(1))   state <= ST_RUN;
          else                      tmo <= tmo - TW'(1);
        end
        ST_RUN: begin
          if (last) begin
            state   <= ST_IDLE;
            sel_map <= '0;
          end else begin
            rem <= rem - RW'(1);
            if (cmd_susp) begin
              state <= ST_SPEND;
              lat   <= L_LOAD;
            end
          end
        end
        ST_SPEND: begin
          if (last) begin
            state   <= ST_IDLE;
            sel_map <= '0;
          end else begin
            rem <= rem - RW'(1);
            if (lat == LW'(1)) state <= ST_SUSP;
            else               lat <= lat - LW'(1);
          end
        end
        ST_SUSP: begin
          if (cmd_res) state <= ST_RUN;
        end
        ST_CHIP: begin
          if (last) begin
            state   <= ST_IDLE;
            sel_map <= '0;
          end else begin
            rem <= rem - RW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CHIP_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHIP && !last) |=> state == ST_CHIP) else $error("chip erase disturbed"); // R4
  AST_TMO_SUSP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TMO && cmd_susp) |=> state == ST_SUSP) else $error("time-out suspend late"); // R5
  AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SPEND) |-> (lat >= LW'(1) && lat <= L_LOAD)) else $error("suspend latency out of bound"); // R6
  AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP && !cmd_res) |=> state == ST_SUSP) else $error("left suspend without resume"); // R7
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (sel_map == '0)) else $error("selection kept in read mode"); // R8
endmodule

// File: rtl/nes_status_rd.sv
module nes_status_rd
  import nes_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_en,
  input  logic [SECT_W-1:0]      rd_sect,
  input  est_t                   state,
  input  logic [(1<<SECT_W)-1:0] sel_map,
  output logic                   rd_valid,
  output logic                   rd_is_status,
  output logic [7:0]             rd_status
);
  logic t6, t2, hit, susp;

  assign susp = (state == ST_SUSP);
  assign hit  = (state != ST_IDLE) && sel_map[rd_sect];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_is_status <= 1'b0;
      rd_status    <= 8'h00;
      t6           <= 1'b0;
      t2           <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en && hit) begin
        rd_is_status <= 1'b1;
        rd_status    <= {susp, t6, 3'b000, t2, 2'b00};
        t2           <= ~t2;
        if (!susp) t6 <= ~t6;
      end else begin
        rd_is_status <= 1'b0;
        rd_status    <= 8'h00;
      end
    end
  end

  AST_DQ6_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && susp) |=> $stable(t6)) else $error("bit 6 moved while suspended"); // R9
  AST_IDLE_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state == ST_IDLE) |=> !rd_is_status) else $error("status returned in read mode"); // R8
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
  import nes_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SECT_SHIFT = 8,
  parameter int TMO_CYC    = 8,
  parameter int ERASE_CYC  = 40,
  parameter int SUSP_LAT   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic              rd_is_status,
  output logic [7:0]        rd_status,
  output logic              busy,
  output logic              suspended
);
  localparam int SECT_W = ADDR_W - SECT_SHIFT;

  est_t                   state;
  logic [(1<<SECT_W)-1:0] sel_map;
  logic                   chip_go, sec_go;

  nes_unlock_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (state == ST_IDLE),
    .wr_en   (wr_en),
    .wr_low  (wr_addr[10:0]),
    .wr_data (wr_data),
    .chip_go (chip_go),
    .sec_go  (sec_go)
  );

  nes_erase_ctrl #(
    .SECT_W    (SECT_W),
    .TMO_CYC   (TMO_CYC),
    .ERASE_CYC (ERASE_CYC),
    .SUSP_LAT  (SUSP_LAT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .chip_go (chip_go),
    .sec_go  (sec_go),
    .sec_idx (wr_addr[ADDR_W-1:SECT_SHIFT]),
    .state   (state),
    .sel_map (sel_map)
  );

  nes_status_rd #(.SECT_W(SECT_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .rd_sect      (rd_addr[ADDR_W-1:SECT_SHIFT]),
    .state        (state),
    .sel_map      (sel_map),
    .rd_valid     (rd_valid),
    .rd_is_status (rd_is_status),
    .rd_status    (rd_status)
  );

  assign busy      = (state == ST_TMO) || (state == ST_RUN) || (state == ST_SPEND) || (state == ST_CHIP);
  assign suspended = (state == ST_SUSP);

  AST_BUSY_SUSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && suspended)) else $error("busy while suspended"); // R6
endmodule

// File: tb/test_nor_erase_seq.sv
module test_nor_erase_seq;
  localparam int AW = 12, TMO = 8, ERS = 40, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic rd_valid, rd_is_status, busy, suspended;
  logic [7:0] rd_status;

  int nchk = 0, nfail = 0, bcnt = 0, scnt = 0;
  bit t6 = 1'b0, t2 = 1'b0, done = 1'b0;

  nor_erase_seq #(.ADDR_W(AW), .SECT_SHIFT(8), .TMO_CYC(TMO), .ERASE_CYC(ERS), .SUSP_LAT(LAT))
  i_nor_erase_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_is_status(rd_is_status),
    .rd_status(rd_status), .busy(busy), .suspended(suspended)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (busy) bcnt++;
    if (suspended) scnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock5();
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, 16'h0080);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055);
  endtask

  task automatic seq_step(input int k);
    case (k)
      0: wr(12'h555, 16'h00AA);
      1: wr(12'h2AA, 16'h0055);
      2: wr(12'h555, 16'h0080);
      3: wr(12'h555, 16'h00AA);
      4: wr(12'h2AA, 16'h0055);
      default: wr(12'h555, 16'h0010);
    endcase
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // exp_hit: selected sector in erase/suspend; susp: suspended state
  task automatic rd_chk(input logic [AW-1:0] a, input bit exp_hit, input bit susp, input string req);
    logic [7:0] eb;
    eb = exp_hit ? {susp, t6, 3'b000, t2, 2'b00} : 8'h00;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == 1'b1, req, int'(rd_valid), 1);
    chk(rd_is_status == exp_hit, req, int'(rd_is_status), int'(exp_hit));
    chk(rd_status == eb, req, int'(rd_status), int'(eb));
    if (exp_hit) begin
      t2 = ~t2;
      if (!susp) t6 = ~t6;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10", int'(busy), 0);
    chk(suspended == 1'b0, "R10", int'(suspended), 0);
    chk(rd_valid == 1'b0, "R10", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk(12'h100, 1'b0, 1'b0, "R8 idle read");

    // R1 chip erase length
    unlock5();
    bcnt = 0;
    wr(12'h555, 16'h0010);
    chk(busy == 1'b1, "R1 start", int'(busy), 1);
    wait_idle();
    chk(bcnt == ERS, "R1 length", bcnt, ERS);

    // R4 writes ignored in chip erase, R8 all sectors selected
    unlock5();
    bcnt = 0; scnt = 0;
    wr(12'h555, 16'h0010);
    wr(12'h000, 16'h00B0);
    chk(suspended == 1'b0, "R4 suspend ignored", int'(suspended), 0);
    unlock5();
    wr(12'h312, 16'h0030);
    rd_chk(12'hA00, 1'b1, 1'b0, "R8 chip erase status");
    rd_chk(12'hF7F, 1'b1, 1'b0, "R9 chip erase toggle");
    wait_idle();
    chk(bcnt == ERS, "R4 length", bcnt, ERS);
    chk(scnt == 0, "R4 never suspended", scnt, 0);

    // R2/R8 sector sweep
    for (int s = 0; s < 16; s++) begin
      unlock5();
      bcnt = 0;
      wr({4'(s), 8'h3C}, 16'h0030);
      rd_chk({4'(s), 8'h00}, 1'b1, 1'b0, "R8 selected sector");
      rd_chk({4'((s + 1) % 16), 8'h00}, 1'b0, 1'b0, "R8 unselected sector");
      wait_idle();
      chk(bcnt == TMO + ERS, "R2 length", bcnt, TMO + ERS);
      rd_chk({4'(s), 8'h00}, 1'b0, 1'b0, "R8 after done");
    end

    // R3 broken sequence sweep
    for (int k = 0; k < 6; k++) begin
      bcnt = 0;
      for (int j = 0; j < k; j++) seq_step(j);
      wr(12'h555, 16'h0001);
      for (int j = k + 1; j < 6; j++) seq_step(j);
      repeat (2) @(negedge clk);
      chk(bcnt == 0, "R3 no erase after break", bcnt, 0);
    end
    bcnt = 0;
    for (int j = 0; j < 6; j++) seq_step(j);
    wait_idle();
    chk(bcnt == ERS, "R3 accepted after break", bcnt, ERS);

    // R5 suspend in time-out
    unlock5();
    wr(12'h3AB, 16'h0030);
    repeat (2) @(negedge clk);
    wr(12'h000, 16'h00B0);
    chk(suspended == 1'b1, "R5 immediate suspend", int'(suspended), 1);
    chk(busy == 1'b0, "R5 not busy", int'(busy), 0);
    rd_chk(12'h300, 1'b1, 1'b1, "R9 suspended status");
    rd_chk(12'h3FF, 1'b1, 1'b1, "R9 suspended toggle");
    rd_chk(12'h400, 1'b0, 1'b1, "R8 unselected in suspend");
    wr(12'h555, 16'h0010);
    wr(12'h000, 16'h00B0);
    chk(suspended == 1'b1, "R7 other writes ignored", int'(suspended), 1);
    bcnt = 0;
    wr(12'h000, 16'h0030);
    chk(busy == 1'b1, "R7 resume", int'(busy), 1);
    wait_idle();
    chk(bcnt == ERS, "R5 full erase after resume", bcnt, ERS);

    // R6 suspend while running, R7 30h while running ignored
    unlock5();
    bcnt = 0;
    wr(12'h7C0, 16'h0030);
    repeat (TMO + 3) @(negedge clk);
    wr(12'h000, 16'h0030);
    chk(suspended == 1'b0, "R7 resume while running ignored", int'(suspended), 0);
    wr(12'h000, 16'h00B0);
    begin
      int n;
      n = 0;
      while (!suspended && n < 100) begin
        @(negedge clk);
        n++;
      end
      chk(n == LAT, "R6 suspend latency", n, LAT);
    end
    rd_chk(12'h700, 1'b1, 1'b1, "R9 suspended after run");
    wr(12'h000, 16'h0030);
    wait_idle();
    chk(bcnt == TMO + ERS, "R6 total busy", bcnt, TMO + ERS);

    // R10 reset aborts a running erase
    unlock5();
    wr(12'h900, 16'h0030);
    repeat (TMO + 5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(busy == 1'b0, "R10 abort", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    t6 = 1'b0; t2 = 1'b0;
    rd_chk(12'h900, 1'b0, 1'b0, "R10 no selection after reset");
    chk(suspended == 1'b0, "R10 not suspended", int'(suspended), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule